// File: doc/BRIEF.md
# Fractional UART Baud Rate Generator

This block divides a fixed reference clock (120 MHz in the intended system) into two single-cycle clock-enable pulses for a UART: an oversample tick and a bit-rate tick. The divide ratio has two parts. A 14-bit integer divisor sets the length of each oversample period in reference cycles. A 4-bit fractional code, counted in sixteenths of a reference cycle, stretches some of those periods by one cycle. The long-run average period is therefore the integer plus the code divided by 16.

A mode input selects 16 or 10 oversample ticks per bit. At the fastest setting the oversample tick is high on every reference cycle, which in 10x mode gives 12 Mbaud from 120 MHz. Large integer divisors reach down to a few hundred baud.

Configuration is captured only on a load strobe. The load also restarts every counter, so the first pulses after a change are whole periods of the new setting. UART framing, FIFOs and configuration storage live outside the block.

Top module: `frac_baud_gen`

## Requirements
- R1: With an integer divisor D of 2 or more and a fractional code of 0, consecutive oversample ticks are exactly D reference cycles apart, and the tick is high for one cycle only.
- R2: With D equal to 0 or 1 (bypass), the oversample tick is high on every reference cycle from the first period on, and the fractional code has no effect.
- R3: In 16x mode (mode input 0), exactly 16 oversample ticks occur per bit-rate tick. Every bit period, including the first after a load, lasts exactly 16·D + F reference cycles, where F is the fractional code (D ≥ 2).
- R4: In 10x mode (mode input 1), exactly 10 oversample ticks occur per bit-rate tick. Each bit period P satisfies |16·P − 10·(16·D + F)| < 16. Eight consecutive bit periods after a load total exactly 5·(16·D + F) cycles.
- R5: A bit-rate tick is only ever high in a cycle where the oversample tick is also high.
- R6: Changes on the divisor, fraction and mode inputs without a load strobe leave both tick periods unchanged.
- R7: A load strobe sampled at a clock edge forces both ticks low in the following cycle. The first oversample tick is seen max(D,1) edges after that load edge, and the first bit-rate tick after 16 or 10 complete oversample periods.
- R8: While reset (active low) is asserted both ticks are low. After release the block runs with D = RST_DIV (default 4), F = 0 and 16x mode, so the first oversample tick comes 4 cycles and the first bit-rate tick 64 cycles after the release.
- R9: With D ≥ 2 every oversample period lasts either D or D + 1 reference cycles. Over 16 consecutive periods after a load exactly F of them last D + 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| load_i | input | 1 | Capture divisor, fraction and mode, and restart all counters |
| div_int_i | input | 14 | Integer divisor D (0 and 1 select bypass) |
| div_frac_i | input | 4 | Fractional code F, in sixteenths of a reference cycle |
| mode_x10_i | input | 1 | 0: 16 oversample ticks per bit, 1: 10 per bit |
| os_tick_o | output | 1 | One-cycle oversample enable |
| bit_tick_o | output | 1 | One-cycle bit-rate enable, aligned with an oversample tick |

## Verification
Random settings of D, F and mode are mixed with directed ones: bypass with a non-zero fraction, D = 2 with the largest fraction, a large divisor, and a change of the inputs without a load. The bench measures every oversample and bit interval against values computed from the settings. A fraction of zero separates the pure integer path from the stretch logic. 16x settings catch any drift of the fractional accumulator, because every bit period there must be exact. 10x settings with eight bits check that the accumulator error stays bounded per bit and cancels over the run. Load latency and the post-reset defaults are checked against the cycle in which the first tick must appear.

// File: rtl/baud_pkg.sv
// Package: shared types and constants for the fractional baud generator.
// Assumes the oversample ratios are fixed at 16 and 10 ticks per bit.
package baud_pkg;

    typedef enum logic {
        OS_X16 = 1'b0,
        OS_X10 = 1'b1
    } os_mode_e;

    localparam int OS_RATIO_HI = 16;
    localparam int OS_RATIO_LO = 10;
    localparam int OS_W        = $clog2(OS_RATIO_HI);

    // Last count value of the oversample counter for a mode.
    function automatic logic [OS_W-1:0] os_last(input os_mode_e mode);
        if (mode == OS_X10) begin
            os_last = OS_W'(OS_RATIO_LO - 1);
        end else begin
            os_last = OS_W'(OS_RATIO_HI - 1);
        end
    endfunction

endpackage

// File: rtl/baud_cfg_hold.sv
// Module: holds the active divisor configuration.
// Captures divisor, fraction and mode on a load strobe and pre-decodes the
// bypass flag and the last prescaler count, so that the per-cycle compare
// path in the prescaler stays short. Assumes RST_DIV fits in DIV_W bits.
module baud_cfg_hold
    import baud_pkg::*;
#(
    parameter int DIV_W   = 14,
    parameter int FRAC_W  = 4,
    parameter int RST_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DIV_W-1:0]  div_i,
    input  logic [FRAC_W-1:0] frac_i,
    input  logic              mode_i,
    output logic [DIV_W-1:0]  last_base_o,
    output logic [FRAC_W-1:0] frac_o,
    output logic              bypass_o,
    output os_mode_e          mode_o
);

    localparam logic [DIV_W-1:0] ONE      = DIV_W'(1);
    localparam logic [DIV_W-1:0] RST_D    = DIV_W'(RST_DIV);
    localparam logic             RST_BYP  = (RST_DIV <= 1);
    localparam logic [DIV_W-1:0] RST_LAST = RST_BYP ? '0 : RST_D - ONE;

    logic             in_bypass;
    logic [DIV_W-1:0] in_last;

    // Decode the incoming divisor into bypass flag and last count.
    always_comb begin
        in_bypass = (div_i <= ONE);
        in_last   = in_bypass ? '0 : div_i - ONE;
    end

    // Capture the decoded configuration on a load strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_base_o <= RST_LAST;
            frac_o      <= '0;
            bypass_o    <= RST_BYP;
            mode_o      <= OS_X16;
        end else if (load_i) begin
            last_base_o <= in_last;
            frac_o      <= frac_i;
            bypass_o    <= in_bypass;
            mode_o      <= os_mode_e'(mode_i);
        end
    end

endmodule

// File: rtl/baud_frac_prescaler.sv
// Module: integer prescaler with fractional period stretching.
// Counts reference cycles up to the last count; when the fractional
// accumulator plus the code carries out, the current period is one cycle
// longer. The accumulator advances on each wrap. Assumes last_base_i is
// below 2**DIV_W - 1 when not in bypass, so the stretch cannot overflow.
module baud_frac_prescaler #(
    parameter int DIV_W  = 14,
    parameter int FRAC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic [DIV_W-1:0]  last_base_i,
    input  logic [FRAC_W-1:0] frac_i,
    input  logic              bypass_i,
    output logic              wrap_o,
    output logic              os_tick_o
);

    logic [DIV_W-1:0]  cnt_q;
    logic [FRAC_W-1:0] acc_q;
    logic [FRAC_W:0]   acc_sum;
    logic              stretch;
    logic [DIV_W-1:0]  last_cnt;

    // Work out whether this period is stretched and where it ends.
    always_comb begin
        acc_sum  = {1'b0, acc_q} + {1'b0, frac_i};
        stretch  = !bypass_i && acc_sum[FRAC_W];
        last_cnt = last_base_i + DIV_W'(stretch);
        wrap_o   = (cnt_q == last_cnt);
    end

    // Advance the cycle counter, the accumulator and the registered tick.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt_q     <= '0;
            acc_q     <= '0;
            os_tick_o <= 1'b0;
        end else begin
            os_tick_o <= wrap_o;
            if (wrap_o) begin
                cnt_q <= '0;
                acc_q <= bypass_i ? '0 : acc_sum[FRAC_W-1:0];
            end else begin
                cnt_q <= cnt_q + DIV_W'(1);
            end
        end
    end

endmodule

// File: rtl/baud_os_divider.sv
// Module: divides oversample periods down to the bit rate.
// Counts prescaler wraps and raises the bit tick on the wrap that ends the
// 16th or 10th period, so it is aligned with an oversample tick. Assumes
// wrap_i is the same-cycle wrap strobe that feeds the oversample tick.
module baud_os_divider
    import baud_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     clr_i,
    input  logic     wrap_i,
    input  os_mode_e mode_i,
    output logic     bit_tick_o
);

    logic [OS_W-1:0] os_cnt_q;
    logic [OS_W-1:0] os_end;
    logic            at_end;

    // Select the last oversample count for the active mode.
    always_comb begin
        os_end = os_last(mode_i);
        at_end = (os_cnt_q == os_end);
    end

    // Count oversample periods and emit the bit tick on the last one.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            os_cnt_q   <= '0;
            bit_tick_o <= 1'b0;
        end else begin
            bit_tick_o <= wrap_i && at_end;
            if (wrap_i) begin
                os_cnt_q <= at_end ? '0 : os_cnt_q + OS_W'(1);
            end
        end
    end

endmodule

// File: rtl/frac_baud_gen.sv
// Module: top of the fractional UART baud rate generator.
// Joins the configuration holder, the fractional prescaler and the
// oversample divider. Assumes a single reference clock domain and that
// load_i is a synchronous one-cycle (or longer) strobe.
module frac_baud_gen
    import baud_pkg::*;
#(
    parameter int DIV_W   = 14,
    parameter int FRAC_W  = 4,
    parameter int RST_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DIV_W-1:0]  div_int_i,
    input  logic [FRAC_W-1:0] div_frac_i,
    input  logic              mode_x10_i,
    output logic              os_tick_o,
    output logic              bit_tick_o
);

    logic [DIV_W-1:0]  last_base;
    logic [FRAC_W-1:0] frac_act;
    logic              bypass;
    os_mode_e          mode_act;
    logic              wrap;

    baud_cfg_hold #(
        .DIV_W   (DIV_W),
        .FRAC_W  (FRAC_W),
        .RST_DIV (RST_DIV)
    ) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load_i),
        .div_i       (div_int_i),
        .frac_i      (div_frac_i),
        .mode_i      (mode_x10_i),
        .last_base_o (last_base),
        .frac_o      (frac_act),
        .bypass_o    (bypass),
        .mode_o      (mode_act)
    );

    baud_frac_prescaler #(
        .DIV_W  (DIV_W),
        .FRAC_W (FRAC_W)
    ) u_pre (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (load_i),
        .last_base_i (last_base),
        .frac_i      (frac_act),
        .bypass_i    (bypass),
        .wrap_o      (wrap),
        .os_tick_o   (os_tick_o)
    );

    baud_os_divider u_osd (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (load_i),
        .wrap_i     (wrap),
        .mode_i     (mode_act),
        .bit_tick_o (bit_tick_o)
    );

endmodule

// File: rtl/frac_baud_gen_chk.sv
// Module: assertion checker bound to frac_baud_gen.
// Observes the tick outputs, the load strobe and the held configuration,
// and measures the oversample period with its own gap counter.
module frac_baud_gen_chk #(
    parameter int DIV_W = 14
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load_i,
    input logic             os_tick_o,
    input logic             bit_tick_o,
    input logic             bypass,
    input logic [DIV_W-1:0] last_base
);

    localparam int GAP_W = DIV_W + 2;

    logic [GAP_W-1:0] gap_q;
    logic             seen_q;
    logic [GAP_W-1:0] per_lo;
    logic [GAP_W-1:0] per_hi;

    // Allowed oversample period bounds for the held divisor.
    always_comb begin
        per_lo = GAP_W'(last_base) + GAP_W'(1);
        per_hi = GAP_W'(last_base) + GAP_W'(2);
    end

    // Measure cycles since the previous oversample tick.
    always_ff @(posedge clk) begin
        if (!rst_n || load_i) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (os_tick_o) begin
            gap_q  <= GAP_W'(1);
            seen_q <= 1'b1;
        end else if (gap_q != '1) begin
            gap_q <= gap_q + GAP_W'(1);
        end
    end

    assert_bit_on_os_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick_o |-> os_tick_o);

    assert_quiet_after_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (!os_tick_o && !bit_tick_o));

    assert_quiet_in_reset_R8: assert property (@(posedge clk)
        !rst_n |=> (!os_tick_o && !bit_tick_o));

    assert_single_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (os_tick_o && !bypass) |=> !os_tick_o);

    assert_bypass_every_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (os_tick_o && bypass && !load_i) |=> os_tick_o);

    assert_period_bounds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (os_tick_o && seen_q && !bypass) |-> (gap_q == per_lo || gap_q == per_hi));

endmodule

bind frac_baud_gen frac_baud_gen_chk #(.DIV_W(DIV_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load_i),
    .os_tick_o  (os_tick_o),
    .bit_tick_o (bit_tick_o),
    .bypass     (bypass),
    .last_base  (last_base)
);

// File: tb/sim_frac_baud_gen.sv
`timescale 1ns/1ps
module sim_frac_baud_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_i = 1'b0;
    logic [13:0] div_int_i = '0;
    logic [3:0]  div_frac_i = '0;
    logic        mode_x10_i = 1'b0;
    logic        os_tick_o;
    logic        bit_tick_o;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int t0       = 0;
    bit wd_hit   = 1'b0;
    bit done     = 1'b0;

    frac_baud_gen u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load_i),
        .div_int_i  (div_int_i),
        .div_frac_i (div_frac_i),
        .mode_x10_i (mode_x10_i),
        .os_tick_o  (os_tick_o),
        .bit_tick_o (bit_tick_o)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Watchdog: an overlong run counts as a failure.
    always @(posedge clk) begin
        if (!done && !wd_hit && cyc > 190000) begin
            wd_hit = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected < 190000", cyc);
        end
    end

    task automatic check(input bit ok, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    function automatic int base_len(input int d);
        return (d <= 1) ? 1 : d;
    endfunction

    function automatic int frac_eff(input int d, input int f);
        return (d <= 1) ? 0 : f;
    endfunction

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    // Apply a configuration with a one-cycle load strobe.
    task automatic do_load(input int d, input int f, input int m);
        @(negedge clk);
        div_int_i  = 14'(d);
        div_frac_i = 4'(f);
        mode_x10_i = m[0];
        load_i     = 1'b1;
        @(negedge clk);
        load_i = 1'b0;
        t0 = cyc;
        check(!os_tick_o && !bit_tick_o, "R7 ticks low after load",
              int'(os_tick_o) + int'(bit_tick_o), 0);
    endtask

    // Measure nb bit periods from t0 against the expected setting.
    task automatic measure(input int d, input int f, input int m, input int nb);
        int base, fe, n, t_os, t_bit, os_since, bits, bad_os, bad_coin, per, ideal16;
        bit got_os;
        base = base_len(d);
        fe   = frac_eff(d, f);
        n    = m ? 10 : 16;
        ideal16 = n * (16 * base + fe);
        t_os = t0; t_bit = t0; bits = 0; got_os = 1'b0;
        os_since = 0; bad_os = 0; bad_coin = 0;
        while (bits < nb && !wd_hit) begin
            @(negedge clk);
            if (os_tick_o) begin
                if (!got_os) begin
                    check(cyc - t0 == base, "R7 first oversample tick delay", cyc - t0, base);
                    got_os = 1'b1;
                end else if (!((cyc - t_os) == base || (fe != 0 && (cyc - t_os) == base + 1))) begin
                    bad_os++;
                    $display("  oversample period %0d for D=%0d F=%0d", cyc - t_os, d, fe);
                end
                t_os = cyc;
                os_since++;
            end
            if (bit_tick_o) begin
                if (!os_tick_o) bad_coin++;
                per = cyc - t_bit;
                if (m == 0)
                    check(per == 16 * base + fe, "R3 16x bit period", per, 16 * base + fe);
                else
                    check(iabs(16 * per - ideal16) < 16, "R4 10x bit period x16 vs ideal",
                          16 * per, ideal16);
                check(os_since == n, "R3 R4 oversample ticks per bit", os_since, n);
                os_since = 0;
                t_bit = cyc;
                bits++;
            end
        end
        check(bad_os == 0, "R1 R2 R9 oversample period violations", bad_os, 0);
        check(bad_coin == 0, "R5 bit tick without oversample tick", bad_coin, 0);
        if (((nb * n) % 16) == 0)
            check(t_bit - t0 == (nb * ideal16) / 16, "R3 R4 total over run",
                  t_bit - t0, (nb * ideal16) / 16);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // R8: reset behaviour and defaults.
        repeat (5) @(negedge clk);
        check(!os_tick_o && !bit_tick_o, "R8 ticks low in reset",
              int'(os_tick_o) + int'(bit_tick_o), 0);
        rst_n = 1'b1;
        t0 = cyc;
        measure(4, 0, 0, 2);

        // Directed corner cases.
        do_load(7, 0, 0);  measure(7, 0, 0, 3);    // R1 integer only
        do_load(0, 5, 1);  measure(0, 5, 1, 8);    // R2 bypass, fraction ignored
        do_load(1, 9, 0);  measure(1, 9, 0, 3);    // R2 bypass in 16x
        do_load(2, 15, 0); measure(2, 15, 0, 3);   // R9 largest fraction
        do_load(3, 7, 1);  measure(3, 7, 1, 8);    // R4 10x with fraction
        do_load(300, 1, 0); measure(300, 1, 0, 2); // R3 large divisor

        // R6: inputs change without a load.
        do_load(7, 3, 0);
        @(negedge clk);
        div_int_i = 14'd20; div_frac_i = 4'd9; mode_x10_i = 1'b1;
        measure(7, 3, 0, 3);

        // Constrained random settings.
        for (int i = 0; i < 12; i++) begin
            int d, f, m;
            d = 2 + int'($urandom_range(0, 40));
            f = int'($urandom_range(0, 15));
            m = int'($urandom_range(0, 1));
            do_load(d, f, m);
            measure(d, f, m, m ? 8 : 3);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // End a run cut short by the watchdog with the summary line.
    always @(posedge clk) begin
        if (wd_hit && !done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule